// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a bank of programmable windows that carve regions out of the local bus address space and redirect them to addresses on the PCIe side. Each window has an enable, an access kind (configuration, I/O or memory), a 64-bit size mask, a 64-bit local base and a 64-bit remote target. Software-facing logic elsewhere writes the window fields through a simple 32-bit write port. Each write names a window index and a field selector.

A lookup port accepts a local address together with a valid strobe. One clock later the block reports whether a window claimed the address, which window it was, its access kind and the translated remote address.

Memory and I/O windows keep the address offset inside the window and merge it with the target base. Configuration windows do something different: they build a configuration-space address from a bus/device/function number held in the window's target register and the 4 KB register offset of the request.

Top module: `owin_xlate`

## Requirements
- R1: Reset disables every window and clears the result outputs; after reset every lookup misses until a window is enabled again.
- R2: A write with `cfg_we` high updates one field of window `cfg_win`, chosen by `cfg_sel`: 0 control, 1 mask upper 32 bits, 2 local base low, 3 local base high, 4 target low, 5 target high. Selector values 6 and 7 change nothing. The control word holds the enable in bit 0, the kind in bits 2:1 and mask bits 31:12 in bits 31:12. A write is seen by lookups presented in the cycle after its clock edge.
- R3: A window claims an address when it is enabled and (address AND mask) equals (base AND mask). Bits 11:0 of the written base are ignored, and mask bits 11:0 always read as zero (4 KB granularity).
- R4: For kinds 1 (I/O), 2 (memory) and 3, the translated address is target OR (address AND NOT mask), using the full 64-bit mask. Bits 11:0 of the written target low register are ignored.
- R5: For kind 0 (configuration), the translated address is zero in bits 63:32 and 15:12. Bits 31:16 come from target-low bits 31:16 (bus, device, function). Bits 11:0 are the request address bits 11:0.
- R6: When several windows claim an address, the lowest-numbered one is reported.
- R7: On a miss, `rs_hit`, `rs_win`, `rs_type` and `rs_addr` are all zero.
- R8: The result appears exactly one clock after the lookup is presented. `rs_valid` follows `lk_valid` with one cycle of delay, and no hit is reported without a lookup.
- R9: A window whose enable bit is clear never claims an address, even when its other fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_win | input | 3 | Window index of the write |
| cfg_sel | input | 3 | Field selector of the write |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 64 | Local address to translate |
| rs_valid | output | 1 | Result strobe, one cycle after `lk_valid` |
| rs_hit | output | 1 | A window claimed the address |
| rs_win | output | 3 | Index of the claiming window |
| rs_type | output | 2 | Access kind of the claiming window |
| rs_addr | output | 64 | Translated remote address |

## Verification
The assertions check the following on every cycle:
- the one-cycle relation between `lk_valid` and `rs_valid`;
- that no hit is reported without a lookup;
- that every miss gives all-zero results;
- that a hit always keeps the request's low 12 address bits;
- that configuration results have zero upper and 15:12 bits;
- that no hit appears right after reset.

Other behaviours depend on which values were written, so only the directed scenarios can show them:
- the decoding of each field selector;
- the ignored base and target bits;
- the effect of the upper mask half;
- the insertion of the bus/device/function number;
- lowest-index priority between overlapping windows;
- the effect of clearing an enable.

// File: rtl/owin_pkg.sv
package owin_pkg;

    localparam int ADDR_W    = 64;
    localparam int REG_W     = 32;
    localparam int GRAN_BITS = 12;

    typedef enum logic [1:0] {
        WT_CFG = 2'd0,
        WT_IO  = 2'd1,
        WT_MEM = 2'd2,
        WT_RSV = 2'd3
    } win_type_e;

    typedef enum logic [2:0] {
        RS_CTRL    = 3'd0,
        RS_MASK_HI = 3'd1,
        RS_BASE_LO = 3'd2,
        RS_BASE_HI = 3'd3,
        RS_TGT_LO  = 3'd4,
        RS_TGT_HI  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        win_type_e         kind;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] tgt;
    } win_cfg_t;

    // Window claims the address when enabled and the masked bits agree.
    function automatic logic win_match(win_cfg_t w, logic [ADDR_W-1:0] a);
        return w.en && ((a & w.mask) == (w.base & w.mask));
    endfunction

    // Remote address formed for a claimed request.
    function automatic logic [ADDR_W-1:0] win_translate(win_cfg_t w, logic [ADDR_W-1:0] a);
        if (w.kind == WT_CFG)
            return {32'h0, w.tgt[31:16], 4'h0, a[GRAN_BITS-1:0]};
        return w.tgt | (a & ~w.mask);
    endfunction

endpackage

// File: rtl/owin_regfile.sv
module owin_regfile
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] win,
    input  logic [2:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output win_cfg_t         cfg [NUM_WIN]
);

    localparam logic [GRAN_BITS-1:0] GRAN_ZERO = '0;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        win_cfg_t r;

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we && win == IDX_W'(g)) begin
                case (sel)
                    RS_CTRL: begin
                        r.en         <= wdata[0];
                        r.kind       <= win_type_e'(wdata[2:1]);
                        r.mask[31:0] <= {wdata[31:GRAN_BITS], GRAN_ZERO};
                    end
                    RS_MASK_HI: r.mask[63:32] <= wdata;
                    RS_BASE_LO: r.base[31:0]  <= {wdata[31:GRAN_BITS], GRAN_ZERO};
                    RS_BASE_HI: r.base[63:32] <= wdata;
                    RS_TGT_LO:  r.tgt[31:0]   <= {wdata[31:GRAN_BITS], GRAN_ZERO};
                    RS_TGT_HI:  r.tgt[63:32]  <= wdata;
                    default: ;
                endcase
            end
        end

        assign cfg[g] = r;
    end

endmodule

// File: rtl/owin_match.sv
module owin_match
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  win_cfg_t          cfg  [NUM_WIN],
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_WIN-1:0] hit,
    output logic [ADDR_W-1:0] xl   [NUM_WIN],
    output win_type_e         kind [NUM_WIN]
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign hit[g]  = win_match(cfg[g], addr);
        assign xl[g]   = win_translate(cfg[g], addr);
        assign kind[g] = cfg[g].kind;
    end

endmodule

// File: rtl/owin_pick.sv
module owin_pick
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [NUM_WIN-1:0] hit,
    input  logic [ADDR_W-1:0]  xl   [NUM_WIN],
    input  win_type_e          kind [NUM_WIN],
    output logic               rs_valid,
    output logic               rs_hit,
    output logic [IDX_W-1:0]   rs_win,
    output win_type_e          rs_kind,
    output logic [ADDR_W-1:0]  rs_addr
);

    logic              nx_hit;
    logic [IDX_W-1:0]  nx_idx;
    win_type_e         nx_kind;
    logic [ADDR_W-1:0] nx_addr;

    // Descending scan: the last assignment made is the lowest index.
    always_comb begin
        nx_hit  = 1'b0;
        nx_idx  = '0;
        nx_kind = WT_CFG;
        nx_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (lk_valid && hit[i]) begin
                nx_hit  = 1'b1;
                nx_idx  = IDX_W'(i);
                nx_kind = kind[i];
                nx_addr = xl[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_win   <= '0;
            rs_kind  <= WT_CFG;
            rs_addr  <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= nx_hit;
            rs_win   <= nx_idx;
            rs_kind  <= nx_kind;
            rs_addr  <= nx_addr;
        end
    end

endmodule

// File: rtl/owin_xlate.sv
module owin_xlate
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_win,
    input  logic [2:0]         cfg_sel,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               rs_valid,
    output logic               rs_hit,
    output logic [IDX_W-1:0]   rs_win,
    output logic [1:0]         rs_type,
    output logic [ADDR_W-1:0]  rs_addr
);

    win_cfg_t           cfg  [NUM_WIN];
    logic [NUM_WIN-1:0] hit;
    logic [ADDR_W-1:0]  xl   [NUM_WIN];
    win_type_e          kind [NUM_WIN];
    win_type_e          rs_kind;

    owin_regfile #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .win   (cfg_win),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    owin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg  (cfg),
        .addr (lk_addr),
        .hit  (hit),
        .xl   (xl),
        .kind (kind)
    );

    owin_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .hit      (hit),
        .xl       (xl),
        .kind     (kind),
        .rs_valid (rs_valid),
        .rs_hit   (rs_hit),
        .rs_win   (rs_win),
        .rs_kind  (rs_kind),
        .rs_addr  (rs_addr)
    );

    assign rs_type = rs_kind;

endmodule

// File: rtl/owin_xlate_chk.sv
module owin_xlate_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [11:0]      lk_lo,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic [IDX_W-1:0] rs_win,
    input logic [1:0]       rs_type,
    input logic [63:0]      rs_addr
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rs_hit);

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rs_valid == $past(lk_valid));

    p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> rs_valid);

    p_miss_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !rs_hit |-> (rs_addr == 64'h0 && rs_win == '0 && rs_type == 2'd0));

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> rs_addr[11:0] == $past(lk_lo));

    p_cfg_shape_r5: assert property (@(posedge clk) disable iff (rst)
        (rs_hit && rs_type == 2'd0) |-> (rs_addr[63:32] == 32'h0 && rs_addr[15:12] == 4'h0));

endmodule

bind owin_xlate owin_xlate_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_lo    (lk_addr[11:0]),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_win   (rs_win),
    .rs_type  (rs_type),
    .rs_addr  (rs_addr)
);

// File: tb/owin_xlate_tb.sv
module owin_xlate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        rs_valid;
    logic        rs_hit;
    logic [2:0]  rs_win;
    logic [1:0]  rs_type;
    logic [63:0] rs_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    owin_xlate u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_win(rs_win), .rs_type(rs_type),
        .rs_addr(rs_addr)
    );

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = w; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [63:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic hit, input logic [2:0] w,
                              input logic [1:0] t, input logic [63:0] a);
        chk(req, "rs_valid", 64'(rs_valid), 64'(1'b1));
        chk(req, "rs_hit",   64'(rs_hit),   64'(hit));
        chk(req, "rs_win",   64'(rs_win),   64'(w));
        chk(req, "rs_type",  64'(rs_type),  64'(t));
        chk(req, "rs_addr",  rs_addr,       a);
    endtask

    task automatic t_reset();
        chk("R1", "valid after reset", 64'(rs_valid), 64'(0));
        chk("R1", "hit after reset",   64'(rs_hit),   64'(0));
        look(64'h0);
        expect_res("R1", 1'b0, 3'd0, 2'd0, 64'h0);
    endtask

    task automatic t_mem_window();
        wr(3'd2, 3'd0, 32'hFFFF_0005);   // enable, memory, 64 KB mask
        wr(3'd2, 3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 3'd2, 32'h4000_0123);   // low 12 bits ignored (R3)
        wr(3'd2, 3'd3, 32'h0);
        wr(3'd2, 3'd4, 32'h8000_0FFF);   // low 12 bits ignored (R4)
        wr(3'd2, 3'd5, 32'h0000_0012);
        look(64'h4000_1234);
        expect_res("R3", 1'b1, 3'd2, 2'd2, 64'h0000_0012_8000_1234);
        look(64'h4001_0000);
        expect_res("R7", 1'b0, 3'd0, 2'd0, 64'h0);
    endtask

    task automatic t_upper_mask();
        wr(3'd5, 3'd0, 32'h0000_0003);   // enable, I/O, low mask zero
        wr(3'd5, 3'd1, 32'hFFFF_FFFE);   // 8 GB window
        wr(3'd5, 3'd2, 32'h0);
        wr(3'd5, 3'd3, 32'h0000_0002);
        wr(3'd5, 3'd4, 32'h0);
        wr(3'd5, 3'd5, 32'h0000_0100);
        look(64'h0000_0003_2345_6789);
        expect_res("R4", 1'b1, 3'd5, 2'd1, 64'h0000_0101_2345_6789);
        look(64'h0000_0004_0000_0000);
        expect_res("R4", 1'b0, 3'd0, 2'd0, 64'h0);
    endtask

    task automatic t_cfg_window();
        wr(3'd0, 3'd0, 32'hFFF0_0001);   // enable, configuration, 1 MB
        wr(3'd0, 3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 3'd2, 32'h5000_0000);
        wr(3'd0, 3'd3, 32'h0);
        wr(3'd0, 3'd4, 32'h0321_0ABC);   // bus 3, device 4, function 1
        wr(3'd0, 3'd5, 32'h0000_0077);
        look(64'h5004_5F10);
        expect_res("R5", 1'b1, 3'd0, 2'd0, 64'h0000_0000_0321_0F10);
    endtask

    task automatic t_priority();
        wr(3'd6, 3'd0, 32'hF000_0005);   // 256 MB memory overlapping window 2
        wr(3'd6, 3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 3'd2, 32'h4000_0000);
        wr(3'd6, 3'd3, 32'h0);
        wr(3'd6, 3'd4, 32'hC000_0000);
        wr(3'd6, 3'd5, 32'h0);
        look(64'h4000_1234);
        expect_res("R6", 1'b1, 3'd2, 2'd2, 64'h0000_0012_8000_1234);
        look(64'h4100_0000);
        expect_res("R6", 1'b1, 3'd6, 2'd2, 64'h0000_0000_C100_0000);
    endtask

    task automatic t_disable();
        wr(3'd2, 3'd0, 32'hFFFF_0004);   // enable cleared
        look(64'h4000_1234);
        expect_res("R9", 1'b1, 3'd6, 2'd2, 64'h0000_0000_C000_1234);
    endtask

    task automatic t_bad_sel();
        wr(3'd6, 3'd7, 32'h0);
        wr(3'd6, 3'd6, 32'h0);
        look(64'h4100_0000);
        expect_res("R2", 1'b1, 3'd6, 2'd2, 64'h0000_0000_C100_0000);
    endtask

    task automatic t_no_valid();
        @(negedge clk);
        lk_valid = 1'b0; lk_addr = 64'h4100_0000;
        @(posedge clk); #1;
        chk("R8", "rs_valid idle", 64'(rs_valid), 64'(0));
        chk("R8", "rs_hit idle",   64'(rs_hit),   64'(0));
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        look(64'h4100_0000);
        expect_res("R1", 1'b0, 3'd0, 2'd0, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_mem_window();
        t_upper_mask();
        t_cfg_window();
        t_priority();
        t_disable();
        t_bad_sel();
        t_no_valid();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule